// File: doc/BRIEF.md
# Luma-Chroma Relative Delay Aligner

This block shifts a luma sample stream against a chroma sample stream by a whole number of pixel clocks. The shift is programmable from eight clocks of luma lead to seven clocks of luma lag. Both streams share one pixel-clock enable, and they leave the block with a single common valid flag. Chroma always crosses a fixed reference delay. Luma is taken from a tap on a longer delay line, so the total chroma latency does not depend on the offset.

A 4-bit offset code selects the shift. When its top bit is clear, the low three bits give the luma delay. When its top bit is set, luma leads by the low three bits plus one. The offset code and a bypass request are captured only at the start of a line, so a line is never split between two settings. While bypass is active, chroma leaves the block as zero. A window option limits bypass to the time a vertical-blanking flag is high.

Top module: `lc_align`

## Requirements
- R1: Luma output minus chroma output latency equals the selected offset, counted in enabled pixel clocks, over the range -8 to +7. Chroma latency is always 9 enabled clock edges from input to output, whatever the code.
- R2: After reset, all outputs are zero, out_valid is low, and the active code is 0000, which gives an offset of 0.
- R3: A code with bit 3 equal to 0 delays luma by bits 2:0. For example, 0011 gives +3 and 0111 gives +7.
- R4: A code with bit 3 equal to 1 makes luma lead by bits 2:0 plus one. For example, 1000 gives -1, 1011 gives -4 and 1111 gives -8.
- R5: delay_code and bypass_req are captured only on a clock edge where pix_en and line_start are both high, and they apply from the next enabled edge. Changes at any other time have no effect.
- R6: out_valid repeats in_valid with the chroma latency of 9 enabled edges. out_valid is low after any edge where pix_en is low.
- R7: While bypass is active, chroma_out is zero and luma_out keeps its normal offset behaviour.
- R8: With window_only high, bypass is active only on enabled edges where vblank is high. With window_only low, the captured request alone decides.
- R9: On edges where pix_en is low, every delay stage and both data outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; samples advance only when high |
| line_start | input | 1 | Marks the first sample of a line; loads the settings |
| delay_code | input | 4 | Offset code, sign-magnitude-plus-one format |
| bypass_req | input | 1 | Bypass request for the coming line |
| window_only | input | 1 | Restrict bypass to the vertical-blanking window |
| vblank | input | 1 | Vertical-blanking window flag |
| in_valid | input | 1 | Input sample valid |
| luma_in | input | DW | Luma sample |
| chroma_in | input | DW | Chroma sample |
| out_valid | output | 1 | Output sample valid |
| luma_out | output | DW | Aligned luma sample |
| chroma_out | output | DW | Aligned chroma sample, zero in bypass |

## Verification
The bench builds the block with DW = 10 and the reference depth left at 8. This gives a ramp of several hundred distinct values with no wrap. The difference between the two outputs then reads directly as the offset for every one of the 16 codes, including the zero-length luma path at code 1111. The chroma input carries a fixed bias, so a swap of the two paths or a wrong chroma tap shows up as a value error, not as a hidden match.

// File: rtl/lc_align.sv
module lc_align #(
  parameter int DW  = 8,
  parameter int REF = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_en,
  input  logic                      line_start,
  input  logic [$clog2(REF):0]      delay_code,
  input  logic                      bypass_req,
  input  logic                      window_only,
  input  logic                      vblank,
  input  logic                      in_valid,
  input  logic [DW-1:0]             luma_in,
  input  logic [DW-1:0]             chroma_in,
  output logic                      out_valid,
  output logic [DW-1:0]             luma_out,
  output logic [DW-1:0]             chroma_out
);
  localparam int CW    = $clog2(REF) + 1;
  localparam int DEPTH = 2*REF - 1;
  localparam int TW    = $clog2(2*REF);

  logic [DW-1:0] lsr [1:DEPTH];
  logic [DW-1:0] csr [1:REF];
  logic [REF:1]  vsr;
  logic [CW-1:0] code_q;
  logic          byp_q;
  logic [TW-1:0] tap_d;
  logic [DW-1:0] luma_tap;
  logic          byp_on;

  wire load = pix_en && line_start;

  assign tap_d  = code_q[CW-1] ? TW'(REF-1) - TW'(code_q[CW-2:0])
                               : TW'(REF)   + TW'(code_q[CW-2:0]);
  assign byp_on = byp_q && (!window_only || vblank);

  always_comb begin
    luma_tap = luma_in;
    for (int k = 1; k <= DEPTH; k++)
      if (tap_d == TW'(k)) luma_tap = lsr[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= DEPTH; k++) lsr[k] <= '0;
      for (int k = 1; k <= REF; k++)   csr[k] <= '0;
      vsr        <= '0;
      code_q     <= '0;
      byp_q      <= 1'b0;
      luma_out   <= '0;
      chroma_out <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= pix_en && vsr[REF];
      if (pix_en) begin
        lsr[1] <= luma_in;
        for (int k = 2; k <= DEPTH; k++) lsr[k] <= lsr[k-1];
        csr[1] <= chroma_in;
        for (int k = 2; k <= REF; k++)   csr[k] <= csr[k-1];
        vsr        <= {vsr[REF-1:1], in_valid};
        luma_out   <= luma_tap;
        chroma_out <= byp_on ? '0 : csr[REF];
        if (load) begin
          code_q <= delay_code;
          byp_q  <= bypass_req;
        end
      end
    end
  end

  p_valid_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(luma_out) && $stable(chroma_out));

  p_code_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code_q) && $stable(byp_q));

  p_chroma_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && byp_q && (!window_only || vblank) |=> chroma_out == '0);

  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && !byp_q |=> chroma_out == $past(csr[REF]));
endmodule

// File: tb/lc_align_test.sv
`timescale 1ns/1ps
module lc_align_test;
  localparam int DW   = 10;
  localparam int MOD  = 1 << DW;
  localparam int LAT  = 9;
  localparam int BIAS = 500;

  logic clk = 0, rst_n = 0;
  logic pix_en = 0, line_start = 0, bypass_req = 0, window_only = 0, vblank = 0, in_valid = 0;
  logic [3:0] delay_code = 0;
  logic [DW-1:0] luma_in = 0, chroma_in = 0;
  logic out_valid;
  logic [DW-1:0] luma_out, chroma_out;

  bit en_v = 0, ls_v = 0, br_v = 0, wo_v = 0, vb_v = 0, iv_v = 0;
  logic [3:0] code_v = 0;
  int cnt = 100;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lc_align #(.DW(DW), .REF(8)) uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
    .delay_code(delay_code), .bypass_req(bypass_req), .window_only(window_only),
    .vblank(vblank), .in_valid(in_valid), .luma_in(luma_in), .chroma_in(chroma_in),
    .out_valid(out_valid), .luma_out(luma_out), .chroma_out(chroma_out));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pix_en && rst_n) cnt++;
      pix_en = en_v; line_start = ls_v; bypass_req = br_v; window_only = wo_v;
      vblank = vb_v; in_valid = iv_v; delay_code = code_v;
      luma_in = DW'(cnt); chroma_in = DW'(cnt + BIAS);
    end
  endtask

  function automatic int off_of(logic [3:0] c);
    return c[3] ? -(int'(c[2:0]) + 1) : int'(c[2:0]);
  endfunction

  function automatic int wrap(int v);
    return ((v % MOD) + MOD) % MOD;
  endfunction

  task automatic check_align(int off, bit zero_c, string tag);
    chk(luma_out == DW'(wrap(cnt - LAT - off)), {tag, " luma"}, luma_out, wrap(cnt - LAT - off));
    chk(chroma_out == DW'(zero_c ? 0 : wrap(cnt - LAT + BIAS)), {tag, " chroma"},
        chroma_out, zero_c ? 0 : wrap(cnt - LAT + BIAS));
  endtask

  task automatic load(logic [3:0] c, bit byp);
    code_v = c; br_v = byp; ls_v = 1; tick();
    ls_v = 0; tick(4);
  endtask

  task automatic t_reset();
    tick(3);
    chk(luma_out == 0 && chroma_out == 0, "R2 reset data", luma_out + chroma_out, 0);
    chk(out_valid == 0, "R2 reset valid", out_valid, 0);
    rst_n = 1; en_v = 1; iv_v = 1; tick();
    tick(8);
    chk(out_valid == 0, "R6 valid before latency", out_valid, 0);
    tick();
    chk(out_valid == 1, "R6 valid after latency", out_valid, 1);
    tick(10);
    check_align(0, 0, "R2 default offset");
  endtask

  task automatic t_positive();
    load(4'b0011, 0); check_align(3, 0, "R3 code 0011");
    load(4'b0111, 0); check_align(7, 0, "R3 code 0111");
  endtask

  task automatic t_negative();
    load(4'b1000, 0); check_align(-1, 0, "R4 code 1000");
    load(4'b1011, 0); check_align(-4, 0, "R4 code 1011");
    load(4'b1111, 0); check_align(-8, 0, "R4 code 1111");
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 16; c++) begin
      load(4'(c), 0);
      check_align(off_of(4'(c)), 0, "R1 sweep");
    end
  endtask

  task automatic t_line_only();
    load(4'b0010, 0);
    code_v = 4'b0110; br_v = 1; tick(5);
    check_align(2, 0, "R5 mid-line change ignored");
    ls_v = 1; tick(); ls_v = 0; tick(3);
    check_align(6, 1, "R5 line-start load");
    br_v = 0; load(4'b0000, 0);
  endtask

  task automatic t_bypass();
    load(4'b0101, 1);
    check_align(5, 1, "R7 bypass chroma zero");
    load(4'b0101, 0);
    check_align(5, 0, "R7 bypass released");
  endtask

  task automatic t_window();
    wo_v = 1; vb_v = 0; load(4'b1010, 1);
    check_align(-3, 0, "R8 outside window");
    vb_v = 1; tick(2);
    check_align(-3, 1, "R8 inside window");
    vb_v = 0; tick(2);
    check_align(-3, 0, "R8 window closed");
    wo_v = 0; tick(2);
    check_align(-3, 1, "R8 window off");
    load(4'b0000, 0);
  endtask

  task automatic t_stall();
    logic [DW-1:0] l0, c0;
    load(4'b0100, 0);
    en_v = 0; tick(2);
    l0 = luma_out; c0 = chroma_out;
    tick(5);
    chk(luma_out == l0 && chroma_out == c0, "R9 hold", luma_out, l0);
    chk(out_valid == 0, "R6 valid low in stall", out_valid, 0);
    en_v = 1; tick(2);
    check_align(4, 0, "R9 resume");
    chk(out_valid == 1, "R6 valid after stall", out_valid, 1);
  endtask

  initial begin
    #(200000 * 5.0);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_positive();
    t_negative();
    t_sweep();
    t_line_only();
    t_bypass();
    t_window();
    t_stall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule